// File: doc/BRIEF.md
# EPROM Device Behavioural Model

This block is a synthesizable stand-in for a 128K x 8 ultraviolet-erasable, electrically programmable read-only memory, modelled at its pin interface. Three active-low strobes (chip select, output select, program strobe), a 17-bit address and an 8-bit data input drive it. Two flags replace the analog levels: one says the programming supply is present, the other says the identifier high voltage is on address line 9.

From these inputs the block decodes its operating mode. It returns a stored byte, a fixed identifier byte, or nothing (bus released), and it applies program writes that can only clear bits. A separate one-cycle bulk-erase input models exposure to UV light and returns every location to all ones.

The bus direction is reported as an enable plus a data-out vector, so a surrounding model can build the tri-state pad. Every output is registered and follows the inputs by one clock. The stored depth is a parameter. The full 17-bit address is accepted, but only its low `STORE_AW` bits select a cell, so higher addresses alias.

Top module: `eprom_model`

## Requirements
- R1: With chip select low, output select low, programming flag off and identifier flag off, the clock edge after the inputs are applied shows data_oe=1 and data_out equal to the byte stored at the address.
- R2: With chip select low, output select high and programming flag off, data_oe is 0 after the next edge and no location changes.
- R3: With chip select high, data_oe is 0 after the next edge whatever the other inputs are, and no location changes even with the programming flag on and the program strobe low.
- R4: With programming flag on, chip select low, output select high and program strobe low, the addressed location becomes its old value bitwise AND the input byte, so a 0 bit never returns to 1; data_oe is 0.
- R5: With programming flag on, chip select low, output select low and program strobe high (verify), data_oe is 1 and data_out is the stored byte after the next edge.
- R6: With programming flag on and chip select low, output select and program strobe both high or both low gives data_oe 0 and writes nothing.
- R7: With identifier flag on, programming flag off, chip select and output select low, data_out is 0x97 when address bit 0 is 0 and 0xD6 when it is 1, with data_oe 1.
- R8: A cycle with bulk_erase high sets every location to 0xFF, shows data_oe 0 after that edge, and performs no program write in that cycle.
- R9: After reset data_oe is 0 and every location reads 0xFF.
- R10: Only address bits [STORE_AW-1:0] select a location (default STORE_AW=10), so address A and A+1024 name the same cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, leaves the array erased |
| chip_sel_n | input | 1 | Chip select, active low |
| out_sel_n | input | 1 | Output select, active low |
| prog_n | input | 1 | Program strobe, active low |
| vpp_ok | input | 1 | Programming supply present |
| id_hv | input | 1 | Identifier high voltage on address line 9 |
| bulk_erase | input | 1 | One-cycle erase of the whole array |
| addr | input | 17 | Byte address |
| data_in | input | 8 | Byte to program |
| data_out | output | 8 | Byte driven onto the bus, zero when released |
| data_oe | output | 1 | 1 when the block drives the bus |

## Verification
The assertions relate the mode inputs of one cycle to the bus enable of the next. They therefore take the strobes and flags to be steady for a whole clock. They also assume that reset alone, and not some earlier unknown input, decides the first output. The bench changes every input only on the falling edge, and it holds each combination for exactly one cycle. It releases reset before it applies any mode, so every property sees one well-defined cycle of stimulus. It also never asks for the identifier bytes while the programming flag is on, because that combination is decoded as a programming mode.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] ID_MAKER  = 8'h97;
    localparam logic [DATA_W-1:0] ID_DEVICE = 8'hD6;
    localparam logic [DATA_W-1:0] ERASED    = '1;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_OUT_OFF,
        MD_READ,
        MD_IDENT,
        MD_PROGRAM,
        MD_VERIFY,
        MD_INHIBIT,
        MD_ERASE
    } mode_e;

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] data;
    } bus_t;

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic  chip_sel_n,
    input  logic  out_sel_n,
    input  logic  prog_n,
    input  logic  vpp_ok,
    input  logic  id_hv,
    input  logic  bulk_erase,
    output mode_e mode
);

    // Priority: erase, chip select, programming supply, identifier, read.
    always_comb begin
        if (bulk_erase) begin
            mode = MD_ERASE;
        end else if (chip_sel_n) begin
            mode = MD_STANDBY;
        end else if (vpp_ok) begin
            if (out_sel_n && !prog_n) begin
                mode = MD_PROGRAM;
            end else if (!out_sel_n && prog_n) begin
                mode = MD_VERIFY;
            end else begin
                mode = MD_INHIBIT;
            end
        end else if (!out_sel_n) begin
            mode = id_hv ? MD_IDENT : MD_READ;
        end else begin
            mode = MD_OUT_OFF;
        end
    end

endmodule

// File: rtl/eprom_cells.sv
module eprom_cells
    import eprom_pkg::*;
#(
    parameter int STORE_AW = 10,
    localparam int DEPTH   = 1 << STORE_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wipe,
    input  logic [STORE_AW-1:0] cell_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wipe) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_d[i] = ERASED;
            end
        end else if (wr_en) begin
            // Programming can only pull bits low.
            mem_d[cell_addr] = mem_q[cell_addr] & wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= ERASED;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[cell_addr];

endmodule

// File: rtl/eprom_drive.sv
module eprom_drive
    import eprom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              id_sel,
    input  logic [DATA_W-1:0] cell_data,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    bus_t bus_d, bus_q;

    always_comb begin
        bus_d = '0;
        unique case (mode)
            MD_READ, MD_VERIFY: begin
                bus_d.oe   = 1'b1;
                bus_d.data = cell_data;
            end
            MD_IDENT: begin
                bus_d.oe   = 1'b1;
                bus_d.data = id_sel ? ID_DEVICE : ID_MAKER;
            end
            default: bus_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign data_out = bus_q.data;
    assign data_oe  = bus_q.oe;

endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int STORE_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              out_sel_n,
    input  logic              prog_n,
    input  logic              vpp_ok,
    input  logic              id_hv,
    input  logic              bulk_erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    mode_e             mode;
    logic [DATA_W-1:0] cell_data;

    generate
        if (STORE_AW < ADDR_W) begin : g_alias
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:STORE_AW];
        end
    endgenerate

    eprom_mode_dec u_dec (
        .chip_sel_n (chip_sel_n),
        .out_sel_n  (out_sel_n),
        .prog_n     (prog_n),
        .vpp_ok     (vpp_ok),
        .id_hv      (id_hv),
        .bulk_erase (bulk_erase),
        .mode       (mode)
    );

    eprom_cells #(.STORE_AW(STORE_AW)) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mode == MD_PROGRAM),
        .wipe      (mode == MD_ERASE),
        .cell_addr (addr[STORE_AW-1:0]),
        .wr_data   (data_in),
        .rd_data   (cell_data)
    );

    eprom_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .id_sel    (addr[0]),
        .cell_data (cell_data),
        .data_out  (data_out),
        .data_oe   (data_oe)
    );

endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_sel_n,
    input logic              out_sel_n,
    input logic              prog_n,
    input logic              vpp_ok,
    input logic              id_hv,
    input logic              bulk_erase,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data_in,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe
);

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!bulk_erase && !chip_sel_n && !out_sel_n && !vpp_ok) |=> data_oe); // R1

    AST_OUT_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_sel_n && out_sel_n) |=> !data_oe); // R2

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        chip_sel_n |=> !data_oe); // R3

    AST_BAD_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bulk_erase && !chip_sel_n && vpp_ok && !out_sel_n && !prog_n) |=> !data_oe); // R6

    AST_MAKER_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (!bulk_erase && !chip_sel_n && !out_sel_n && !vpp_ok && id_hv && !addr[0])
        |=> (data_oe && data_out == ID_MAKER)); // R7

    AST_DEVICE_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (!bulk_erase && !chip_sel_n && !out_sel_n && !vpp_ok && id_hv && addr[0])
        |=> (data_oe && data_out == ID_DEVICE)); // R7

    AST_ERASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_erase |=> !data_oe); // R8

    AST_RELEASED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> data_out == '0); // R2

    logic unused_in;
    assign unused_in = ^data_in;

endmodule

bind eprom_model eprom_model_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/eprom_model_tb.sv
module eprom_model_tb;

    localparam int AW    = 17;
    localparam int SAW   = 10;
    localparam int DEPTH = 1 << SAW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_sel_n = 1'b1;
    logic          out_sel_n = 1'b1;
    logic          prog_n = 1'b1;
    logic          vpp_ok = 1'b0;
    logic          id_hv = 1'b0;
    logic          bulk_erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    data_in = '0;
    logic [7:0]    data_out;
    logic          data_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] ref_mem [DEPTH];
    logic [8:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    eprom_model #(.ADDR_W(AW), .STORE_AW(SAW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_sel_n (chip_sel_n),
        .out_sel_n  (out_sel_n),
        .prog_n     (prog_n),
        .vpp_ok     (vpp_ok),
        .id_hv      (id_hv),
        .bulk_erase (bulk_erase),
        .addr       (addr),
        .data_in    (data_in),
        .data_out   (data_out),
        .data_oe    (data_oe)
    );

    // One cycle of stimulus; the expected bus state is queued for the monitor.
    task automatic drive(input logic cs, input logic os, input logic pg,
                         input logic vp, input logic hv, input logic er,
                         input logic [AW-1:0] a, input logic [7:0] d,
                         input string tag);
        logic       en;
        logic [7:0] val;
        int         idx;
        idx = int'(a[SAW-1:0]);
        en  = 1'b0;
        val = 8'h00;
        @(negedge clk);
        chip_sel_n = cs; out_sel_n = os; prog_n = pg;
        vpp_ok = vp; id_hv = hv; bulk_erase = er;
        addr = a; data_in = d;
        if (er) begin
            for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        end else if (cs) begin
            en = 1'b0;
        end else if (vp) begin
            if (os && !pg) ref_mem[idx] = ref_mem[idx] & d;
            else if (!os && pg) begin en = 1'b1; val = ref_mem[idx]; end
        end else if (!os) begin
            en  = 1'b1;
            val = hv ? (a[0] ? 8'hD6 : 8'h97) : ref_mem[idx];
        end
        exp_q.push_back({en, val});
        tag_q.push_back(tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, 8'h00, tag);
    endtask

    task automatic pgm(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, a, d, tag);
    endtask

    // Monitor: compares one queued item per clock, just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [8:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (data_oe !== e[8] || (e[8] && data_out !== e[7:0])) begin
                    bad++;
                    $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
                             t, data_oe, data_out, e[8], e[7:0]);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        total++;
        if (data_oe !== 1'b0) begin
            bad++;
            $display("FAIL R9: got oe=%0b in reset, expected oe=0", data_oe);
        end
        rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (data_oe !== 1'b0) begin
            bad++;
            $display("FAIL R9: got oe=%0b after reset, expected oe=0", data_oe);
        end

        rd(17'd0, "R9 erased after reset");
        rd(17'd1023, "R9 erased top cell");
        pgm(17'd3, 8'hA5, "R4 program quiet");
        rd(17'd3, "R1 read programmed");
        pgm(17'd3, 8'hF0, "R4 one-way AND");
        rd(17'd3, "R4 bits only cleared");
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 17'd3, 8'h00, "R5 verify");
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 17'd3, 8'h00, "R2 output off");
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 17'd3, 8'h00, "R3 standby oe low");
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 17'd7, 8'h00, "R3 standby blocks program");
        rd(17'd7, "R3 cell untouched");
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 17'd8, 8'h00, "R6 both strobes high");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 17'd8, 8'h00, "R6 both strobes low");
        rd(17'd8, "R6 cell untouched");
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 17'h00200, 8'h00, "R7 maker id");
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 17'h00201, 8'h00, "R7 device id");
        pgm(17'd1033, 8'h3C, "R10 program aliased");
        rd(17'd9, "R10 alias read");
        rd(17'h1FC09, "R10 high alias read");
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 17'd5, 8'h00, "R8 erase cycle");
        rd(17'd3, "R8 erased cell 3");
        rd(17'd9, "R8 erased cell 9");
        rd(17'd5, "R8 no write in erase cycle");

        for (int k = 0; k < 40; k++) begin
            logic [AW-1:0] a;
            a = AW'(100 + (k * 37) % 64);
            pgm(a, 8'(k * 29) ^ 8'h5A, "R4 sweep program");
            rd(a, "R1 sweep read");
            drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, a, 8'h00, "R5 sweep verify");
        end

        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 17'd0, 8'h00, "R3 idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule